// File: doc/BRIEF.md
# Byte ALU with Status Flags

`alu8_core` is a purely combinational byte-wide arithmetic and logic unit. It takes two data operands, a carry input, a five-bit operation code and the current status byte. It returns the byte result and the next status byte, and it leaves every flag alone that the chosen operation does not own. The surrounding datapath stores the result and the flags in its own registers.

The unit supports:

- addition and subtraction, each with and without carry;
- bitwise AND, OR, XOR, and clear-under-mask;
- one's and two's complement;
- increment and decrement;
- logical and arithmetic shifts, and rotates through carry;
- nibble exchange;
- load of the second operand, and load of all ones.

Subtract-with-carry never sets Z on its own, so a zero test stays correct across a chain of bytes in a wide subtraction.

The status byte uses fixed bit positions: C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Across all flag-updating operations, the rules are the same:

- N is bit 7 of the result.
- Z is set when the result is zero.
- H is the carry or borrow out of bit 3.
- S is N XOR V, computed whenever N and V are written.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (add) gives a+b and ignores `cin_i`; op 1 gives a+b+cin. Both write C (carry out of bit 7), H, V (signed overflow), N and Z.
- R2: Op 2 (subtract) gives a-b and ignores `cin_i`; op 3 gives a-b-cin. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow. Op 2 sets Z when the result is zero. Op 3 sets Z only when the result is zero and the incoming Z was 1.
- R3: Ops 4, 5, 6 and 19 (AND, OR, XOR, and a AND NOT b) give the bitwise result, force V to 0, write Z and N, and keep C and H.
- R4: Op 7 gives 0xFF minus a, sets C to 1, clears V, writes Z and N, and keeps H.
- R5: Op 8 gives 0x00 minus a. C is 1 when a is nonzero, V is 1 when a is 0x80, and H is 1 when bits 3..0 of a are nonzero. Z and N are written.
- R6: Op 9 (a+1) and op 10 (a-1) write Z, N and V, and keep C and H. V is set when the increment starts from 0x7F or the decrement starts from 0x80.
- R7: Shifts and rotates:
  - Op 11 shifts left and fills bit 0 with 0.
  - Op 12 shifts right and fills bit 7 with 0.
  - Op 13 rotates left with `cin_i` entering bit 0.
  - Op 14 rotates right with `cin_i` entering bit 7.
  - Op 15 shifts right and keeps bit 7.
  
  C receives the bit shifted out, and H is kept.
- R8: For ops 11 to 15, V equals N XOR C of the new result.
- R9: Op 16 exchanges bits 3..0 with bits 7..4, op 17 outputs b, and op 18 outputs 0xFF. None of them changes any flag.
- R10: Whenever N or V changes, S of the output equals N XOR V of the output.
- R11: I and T always pass through unchanged. Op codes 20 to 31 output a and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, constant or mask |
| cin_i | input | 1 | Carry in for ops 1, 3, 13, 14 |
| op_i | input | 5 | Operation code |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Operation result |
| flags_o | output | 8 | Next status byte |

## Verification
The checker evaluates its rules only while every input is known, because an undefined operation code or status byte carries no meaning for the flag rules. The stimulus always drives fully defined values through a task at the falling clock edge, so inputs are stable well before outputs are sampled. Status bytes with I, T, C and H set are mixed in deliberately, so that the kept-flag rules see ones as well as zeros.

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic [4:0]    op_i,
  input  logic [7:0]    flags_i,
  output logic [DW-1:0] result_o,
  output logic [7:0]    flags_o
);
  localparam int HB = DW / 2;
  localparam int MSB = DW - 1;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBC = 5'd3,
    OP_AND = 5'd4, OP_OR  = 5'd5, OP_XOR = 5'd6, OP_COM = 5'd7,
    OP_NEG = 5'd8, OP_INC = 5'd9, OP_DEC = 5'd10, OP_LSL = 5'd11,
    OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_SWP = 5'd16, OP_LDK = 5'd17, OP_SER = 5'd18, OP_CLM = 5'd19
  } op_t;

  logic          is_neg;
  logic [DW-1:0] sx, sy;
  logic [DW:0]   sum, dif;
  logic          add_c, sub_c;
  logic          h_add, h_sub, v_add, v_sub;

  assign is_neg = (op_i == OP_NEG);
  assign add_c  = (op_i == OP_ADC) & cin_i;
  assign sub_c  = (op_i == OP_SBC) & cin_i;
  assign sx     = is_neg ? '0 : a_i;
  assign sy     = is_neg ? a_i : b_i;
  assign sum    = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, add_c};
  assign dif    = {1'b0, sx} - {1'b0, sy} - {{DW{1'b0}}, sub_c};

  assign h_add = (a_i[HB-1] & b_i[HB-1]) | (b_i[HB-1] & ~sum[HB-1]) | (~sum[HB-1] & a_i[HB-1]);
  assign h_sub = (~sx[HB-1] & sy[HB-1]) | (sy[HB-1] & dif[HB-1]) | (dif[HB-1] & ~sx[HB-1]);
  assign v_add = (a_i[MSB] & b_i[MSB] & ~sum[MSB]) | (~a_i[MSB] & ~b_i[MSB] & sum[MSB]);
  assign v_sub = (sx[MSB] & ~sy[MSB] & ~dif[MSB]) | (~sx[MSB] & sy[MSB] & dif[MSB]);

  logic [DW-1:0] res;
  logic c_n, v_n, h_n;
  logic wc, wh, wznv, zchain;

  always_comb begin
    res    = a_i;
    c_n    = flags_i[0];
    v_n    = flags_i[3];
    h_n    = flags_i[5];
    wc     = 1'b0;
    wh     = 1'b0;
    wznv   = 1'b0;
    zchain = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC: begin
        res = sum[DW-1:0]; c_n = sum[DW]; v_n = v_add; h_n = h_add;
        wc = 1'b1; wh = 1'b1; wznv = 1'b1;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        res = dif[DW-1:0]; c_n = dif[DW]; v_n = v_sub; h_n = h_sub;
        wc = 1'b1; wh = 1'b1; wznv = 1'b1; zchain = (op_i == OP_SBC);
      end
      OP_AND: begin res = a_i & b_i;  v_n = 1'b0; wznv = 1'b1; end
      OP_OR:  begin res = a_i | b_i;  v_n = 1'b0; wznv = 1'b1; end
      OP_XOR: begin res = a_i ^ b_i;  v_n = 1'b0; wznv = 1'b1; end
      OP_CLM: begin res = a_i & ~b_i; v_n = 1'b0; wznv = 1'b1; end
      OP_COM: begin
        res = ~a_i; c_n = 1'b1; v_n = 1'b0; wc = 1'b1; wznv = 1'b1;
      end
      OP_INC: begin
        res = a_i + 1'b1; v_n = (a_i == {1'b0, {(DW-1){1'b1}}}); wznv = 1'b1;
      end
      OP_DEC: begin
        res = a_i - 1'b1; v_n = (a_i == {1'b1, {(DW-1){1'b0}}}); wznv = 1'b1;
      end
      OP_LSL: begin res = {a_i[DW-2:0], 1'b0};   c_n = a_i[MSB]; wc = 1'b1; wznv = 1'b1; end
      OP_ROL: begin res = {a_i[DW-2:0], cin_i};  c_n = a_i[MSB]; wc = 1'b1; wznv = 1'b1; end
      OP_LSR: begin res = {1'b0, a_i[DW-1:1]};   c_n = a_i[0];   wc = 1'b1; wznv = 1'b1; end
      OP_ROR: begin res = {cin_i, a_i[DW-1:1]};  c_n = a_i[0];   wc = 1'b1; wznv = 1'b1; end
      OP_ASR: begin res = {a_i[MSB], a_i[DW-1:1]}; c_n = a_i[0]; wc = 1'b1; wznv = 1'b1; end
      OP_SWP: res = {a_i[HB-1:0], a_i[DW-1:HB]};
      OP_LDK: res = b_i;
      OP_SER: res = '1;
      default: res = a_i;
    endcase
    if (op_i inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR})
      v_n = res[MSB] ^ c_n;
  end

  logic n_o, z_o, v_o;
  assign n_o = wznv ? res[MSB] : flags_i[2];
  assign z_o = wznv ? ((res == '0) & (~zchain | flags_i[1])) : flags_i[1];
  assign v_o = wznv ? v_n : flags_i[3];

  assign result_o = res;
  assign flags_o  = {flags_i[7:6],
                     wh ? h_n : flags_i[5],
                     wznv ? (n_o ^ v_o) : flags_i[4],
                     v_o, n_o, z_o,
                     wc ? c_n : flags_i[0]};
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk #(
  parameter int DW = 8
) (
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          cin_i,
  input logic [4:0]    op_i,
  input logic [7:0]    flags_i,
  input logic [DW-1:0] result_o,
  input logic [7:0]    flags_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, op_i, flags_i})) begin
      // R11
      it_pass_chk: assert (flags_o[7:6] == flags_i[7:6]);
      // R3
      if (op_i inside {5'd4, 5'd5, 5'd6, 5'd19})
        logic_flags_chk: assert (flags_o[3] == 1'b0 && flags_o[0] == flags_i[0] && flags_o[5] == flags_i[5]);
      // R6
      if (op_i inside {5'd9, 5'd10})
        incdec_keep_chk: assert (flags_o[0] == flags_i[0] && flags_o[5] == flags_i[5]);
      // R8
      if (op_i inside {[5'd11:5'd15]})
        shift_v_chk: assert (flags_o[3] == (flags_o[2] ^ flags_o[0]));
      // R9
      if (op_i inside {[5'd16:5'd18]})
        noflag_chk: assert (flags_o == flags_i);
      // R10
      if (flags_o[3:2] != flags_i[3:2])
        sign_test_chk: assert (flags_o[4] == (flags_o[2] ^ flags_o[3]));
      // R2
      if (op_i == 5'd3 && !flags_i[1])
        zchain_chk: assert (!flags_o[1]);
      // R11
      if (op_i >= 5'd20)
        spare_op_chk: assert (result_o == a_i && flags_o == flags_i);
      // R4
      if (op_i == 5'd7)
        com_carry_chk: assert (flags_o[0] && !flags_o[3] && (result_o ^ a_i) == '1);
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.DW(DW)) chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i), .flags_i(flags_i),
  .result_o(result_o), .flags_o(flags_o)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0] a_i, b_i, flags_i, result_o, flags_o;
  logic       cin_i;
  logic [4:0] op_i;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  alu8_core uut (.a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i),
                 .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o));

  task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic [7:0] f);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; cin_i = c; flags_i = f;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h (op %0d a %02h b %02h cin %b f %02h)",
               tag, got, exp, op_i, a_i, b_i, cin_i, flags_i);
    end
  endtask

  function automatic logic [7:0] upd(input logic [7:0] old, input logic [7:0] m,
                                     input logic c, input logic z, input logic n,
                                     input logic v, input logic h);
    logic [7:0] e;
    e = old;
    if (m[0]) e[0] = c;
    if (m[1]) e[1] = z;
    if (m[2]) e[2] = n;
    if (m[3]) e[3] = v;
    if (m[5]) e[5] = h;
    if (m[2] | m[3]) e[4] = e[2] ^ e[3];
    return e;
  endfunction

  task automatic t_start;
    drive(5'd0, 8'h00, 8'h00, 1'b0, 8'h00);
    chk("R1 initial zero add result", result_o, 8'h00);
    chk("R1 initial zero add flags", flags_o, 8'h02);
  endtask

  task automatic t_addsub;
    logic [7:0] pa [8] = '{8'h3A, 8'h7F, 8'hFF, 8'h80, 8'h0F, 8'h00, 8'h10, 8'h55};
    logic [7:0] pb [8] = '{8'h27, 8'h01, 8'h01, 8'h80, 8'h01, 8'h00, 8'h20, 8'hAA};
    logic [7:0] fs [2] = '{8'hC2, 8'h40};
    for (int i = 0; i < 8; i++) begin
      for (int op = 0; op < 4; op++) begin
        for (int ci = 0; ci < 2; ci++) begin
          logic [7:0] a, b, r, f;
          int cc, s, sv, sa, sb, lo;
          logic c, h, v, z;
          a = pa[i]; b = pb[i]; f = fs[ci];
          sa = $signed(a); sb = $signed(b);
          cc = (op == 1 || op == 3) ? ci : 0;
          if (op < 2) begin
            s = int'(a) + int'(b) + cc; lo = (a & 15) + (b & 15) + cc;
            sv = sa + sb + cc; c = s > 255; h = lo > 15;
          end else begin
            s = int'(a) - int'(b) - cc; lo = (a & 15) - (b & 15) - cc;
            sv = sa - sb - cc; c = s < 0; h = lo < 0;
          end
          r = s[7:0];
          v = (sv > 127) || (sv < -128);
          z = (r == 8'h00) && (op != 3 || f[1]);
          drive(5'(op), a, b, ci[0], f);
          if (op < 2) begin
            chk("R1 add result", result_o, r);
            chk("R1 add flags", flags_o, upd(f, 8'h2F, c, z, r[7], v, h));
          end else begin
            chk("R2 sub result", result_o, r);
            chk("R2 sub flags", flags_o, upd(f, 8'h2F, c, z, r[7], v, h));
          end
        end
      end
    end
    drive(5'd3, 8'h05, 8'h05, 1'b0, 8'h00);
    chk("R2 chained zero stays clear", flags_o & 8'h02, 8'h00);
  endtask

  task automatic t_logic;
    logic [4:0] ops [4] = '{5'd4, 5'd5, 5'd6, 5'd19};
    logic [7:0] pa [3] = '{8'hF0, 8'h5A, 8'h00};
    logic [7:0] pb [3] = '{8'h0F, 8'hFF, 8'h00};
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 3; i++) begin
        logic [7:0] r;
        case (k)
          0: r = pa[i] & pb[i];
          1: r = pa[i] | pb[i];
          2: r = pa[i] ^ pb[i];
          default: r = pa[i] & (8'hFF - pb[i]);
        endcase
        drive(ops[k], pa[i], pb[i], 1'b1, 8'hE9);
        chk("R3 logic result", result_o, r);
        chk("R3 logic flags", flags_o, upd(8'hE9, 8'h0E, 1'b0, r == 0, r[7], 1'b0, 1'b0));
      end
  endtask

  task automatic t_comneg;
    logic [7:0] pa [5] = '{8'h00, 8'h80, 8'h01, 8'h10, 8'hFF};
    for (int i = 0; i < 5; i++) begin
      logic [7:0] r;
      r = 8'hFF - pa[i];
      drive(5'd7, pa[i], 8'h00, 1'b0, 8'h28);
      chk("R4 complement result", result_o, r);
      chk("R4 complement flags", flags_o, upd(8'h28, 8'h0F, 1'b1, r == 0, r[7], 1'b0, 1'b0));
      r = 8'h00 - pa[i];
      drive(5'd8, pa[i], 8'h00, 1'b1, 8'h00);
      chk("R5 negate result", result_o, r);
      chk("R5 negate flags", flags_o,
          upd(8'h00, 8'h2F, pa[i] != 0, r == 0, r[7], pa[i] == 8'h80, pa[i][3:0] != 0));
    end
  endtask

  task automatic t_incdec;
    logic [7:0] pa [5] = '{8'h7F, 8'hFF, 8'h80, 8'h00, 8'h01};
    for (int i = 0; i < 5; i++) begin
      logic [7:0] r;
      r = pa[i] + 8'h01;
      drive(5'd9, pa[i], 8'h00, 1'b0, 8'h21);
      chk("R6 increment result", result_o, r);
      chk("R6 increment flags", flags_o, upd(8'h21, 8'h0E, 1'b0, r == 0, r[7], pa[i] == 8'h7F, 1'b0));
      r = pa[i] - 8'h01;
      drive(5'd10, pa[i], 8'h00, 1'b0, 8'h21);
      chk("R6 decrement result", result_o, r);
      chk("R6 decrement flags", flags_o, upd(8'h21, 8'h0E, 1'b0, r == 0, r[7], pa[i] == 8'h80, 1'b0));
    end
  endtask

  task automatic t_shift;
    logic [7:0] pa [4] = '{8'h81, 8'h40, 8'h01, 8'hC3};
    for (int op = 11; op <= 15; op++)
      for (int i = 0; i < 4; i++)
        for (int ci = 0; ci < 2; ci++) begin
          logic [7:0] a, r;
          logic c;
          a = pa[i];
          case (op)
            11: begin r = a << 1; c = a[7]; end
            12: begin r = a >> 1; c = a[0]; end
            13: begin r = (a << 1) | 8'(ci); c = a[7]; end
            14: begin r = (a >> 1) | (ci ? 8'h80 : 8'h00); c = a[0]; end
            default: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
          endcase
          drive(5'(op), a, 8'h00, ci[0], 8'h20);
          chk("R7 shift result", result_o, r);
          chk("R8 shift flags", flags_o, upd(8'h20, 8'h0F, c, r == 0, r[7], r[7] ^ c, 1'b0));
        end
  endtask

  task automatic t_noflag;
    drive(5'd16, 8'h3C, 8'h00, 1'b1, 8'hFF);
    chk("R9 swap result", result_o, 8'hC3);
    chk("R9 swap flags", flags_o, 8'hFF);
    drive(5'd17, 8'h12, 8'h00, 1'b0, 8'h00);
    chk("R9 load result", result_o, 8'h00);
    chk("R9 load flags", flags_o, 8'h00);
    drive(5'd18, 8'h12, 8'h34, 1'b0, 8'h5A);
    chk("R9 set-all result", result_o, 8'hFF);
    chk("R9 set-all flags", flags_o, 8'h5A);
    drive(5'd4, 8'h80, 8'hFF, 1'b0, 8'h08);
    chk("R10 sign-test after logic", flags_o & 8'h1C, 8'h14);
    drive(5'd25, 8'h9E, 8'h11, 1'b1, 8'hA5);
    chk("R11 spare op result", result_o, 8'h9E);
    chk("R11 spare op flags", flags_o, 8'hA5);
    drive(5'd0, 8'h01, 8'h02, 1'b0, 8'hC0);
    chk("R11 I and T kept", flags_o & 8'hC0, 8'hC0);
  endtask

  initial begin
    a_i = '0; b_i = '0; cin_i = 1'b0; op_i = '0; flags_i = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_start();
    t_addsub();
    t_logic();
    t_comneg();
    t_incdec();
    t_shift();
    t_noflag();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule